// File: doc/BRIEF.md
# Masked Sticky Interrupt Controller

This block collects sixteen interrupt event sources of a metering front end into one sticky flag register. Each flag latches on its event and holds until the host clears it. A sixteen-bit enable mask selects which flags may pull the shared interrupt line low. The line is modelled as an output enable: when it is asserted, the pad drives 0, and when it is not, the pad floats. An external pull-up then holds the wire high.

The host has two ways to read the flags. A peek read returns the flags and changes nothing. A clearing read returns the flags and empties the register in the same step. Two of the flags are produced inside the block: each one marks the moment the most significant bit of an external energy accumulator rises from 0 to 1, which means the accumulator has reached half scale. A third flag is set once after reset is released, so that the host can tell a reset took place.

Top module: `evt_irq_ctrl`

## Requirements
- R1: A one-cycle high on `evt_in[i]` sets flag `i` at the next clock edge. The flag map is as follows. Bit 0 is active-energy half-full and bit 15 is apparent-energy half-full. Bits 1, 2 and 3 are sag on phases A, B and C. Bits 4, 5 and 6 are zero-crossing timeout on phases A, B and C. Bits 7, 8 and 9 are zero crossing on phases A, B and C. Bit 10 is end of line-cycle accumulation and bit 11 is the reset event. Bit 12 is voltage peak, bit 13 is current peak and bit 14 is new waveform sample.
- R2: A set flag stays set through any number of cycles in which `rd_clear` is low.
- R3: `irq_oe` is 1 exactly when at least one set flag has its mask bit at 1.
- R4: While `rst_n` is low, `status`, `status_rdata`, the mask and `irq_oe` are all 0.
- R5: A 0-to-1 change of `act_msb` sets bit 0, and a 0-to-1 change of `app_msb` sets bit 15. An input that simply stays high sets nothing after a clear.
- R6: A `rd_peek` strobe loads `status_rdata` with the flags at the next edge and leaves every flag unchanged.
- R7: A `rd_clear` strobe loads `status_rdata` with the flags at the next edge and clears all of them, which releases `irq_oe`.
- R8: An event that arrives in the same cycle as a `rd_clear` strobe is set after that strobe and is not lost.
- R9: Flag 11 is set at the first clock edge after reset is released, and it is not set again until the next reset.
- R10: `mask_wr` loads `mask_wdata` into the mask at the next edge. A mask change moves `irq_oe` but leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 16 | Event pulses, one per flag |
| act_msb | input | 1 | Top bit of the active-energy accumulator |
| app_msb | input | 1 | Top bit of the apparent-energy accumulator |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 16 | Mask write data |
| rd_peek | input | 1 | Read strobe, no side effect |
| rd_clear | input | 1 | Read strobe that clears the flags |
| status | output | 16 | Current flag register |
| status_rdata | output | 16 | Flags captured by the last read strobe |
| irq_oe | output | 1 | Pull the interrupt line low when 1 |

## Verification
A table of event and mask pairs drives the masking logic. The table contains single matching bits, set flags with every mask bit away from them, sparse interleaved patterns, and all flags set with only the top mask bit enabled. Together these show whether the request depends on the overlap of flags and mask, rather than on either one alone. Directed sequences then check three things. First, they compare the peek read against the clearing read to confirm that only the clearing read changes state. Second, they raise an event in the same cycle as a clear and confirm it is kept. Third, they hold an accumulator top bit high across a clear to confirm that the half-full flag follows the rising edge and not the level.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int unsigned NFLAG    = 16;
  localparam int unsigned NACC     = 2;
  localparam int unsigned ACT_BIT  = 0;
  localparam int unsigned APP_BIT  = 15;
  localparam int unsigned BOOT_BIT = 11;

  // Flags after one edge: a clearing read empties the register, but flags set in the same cycle survive.
  function automatic logic [NFLAG-1:0] next_flags(
    input logic [NFLAG-1:0] cur,
    input logic [NFLAG-1:0] set,
    input logic             clr
  );
    next_flags = (clr ? '0 : cur) | set;
  endfunction

  // Request when any set flag is enabled.
  function automatic logic irq_request(
    input logic [NFLAG-1:0] flags,
    input logic [NFLAG-1:0] mask
  );
    irq_request = |(flags & mask);
  endfunction

endpackage

// File: rtl/msb_rise_det.sv
module msb_rise_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] msb_in,
  output logic [N-1:0] rise_o
);

  for (genvar g = 0; g < N; g++) begin : g_det
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= msb_in[g];
    end
    assign rise_o[g] = msb_in[g] & ~prev_q;
  end

endmodule

// File: rtl/sticky_flags.sv
module sticky_flags
  import evt_irq_pkg::*;
#(
  parameter int unsigned W = NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flags_o
);

  logic [W-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= next_flags(flags_q, set_i, clr_i);
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/read_port.sv
module read_port #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_peek,
  input  logic         rd_clear,
  input  logic [W-1:0] flags_i,
  output logic [W-1:0] rdata_o
);

  logic [W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rdata_q <= '0;
    else if (rd_peek || rd_clear) rdata_q <= flags_i;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned W = NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_in,
  input  logic         act_msb,
  input  logic         app_msb,
  input  logic         mask_wr,
  input  logic [W-1:0] mask_wdata,
  input  logic         rd_peek,
  input  logic         rd_clear,
  output logic [W-1:0] status,
  output logic [W-1:0] status_rdata,
  output logic         irq_oe
);

  logic [NACC-1:0] acc_msb;
  logic [NACC-1:0] acc_rise;
  logic [W-1:0]    set_vec;
  logic [W-1:0]    mask_q;
  logic            boot_done_q;
  logic            boot_evt;

  assign acc_msb = {app_msb, act_msb};

  msb_rise_det #(.N(NACC)) u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .msb_in (acc_msb),
    .rise_o (acc_rise)
  );

  // One pulse in the first cycle after reset is released.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_done_q <= 1'b0;
    else        boot_done_q <= 1'b1;
  end
  assign boot_evt = ~boot_done_q;

  always_comb begin
    set_vec           = evt_in;
    set_vec[ACT_BIT]  = evt_in[ACT_BIT]  | acc_rise[0];
    set_vec[APP_BIT]  = evt_in[APP_BIT]  | acc_rise[1];
    set_vec[BOOT_BIT] = evt_in[BOOT_BIT] | boot_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  sticky_flags #(.W(W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clr_i   (rd_clear),
    .flags_o (status)
  );

  read_port #(.W(W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_peek  (rd_peek),
    .rd_clear (rd_clear),
    .flags_i  (status),
    .rdata_o  (status_rdata)
  );

  assign irq_oe = irq_request(status, mask_q);

endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         act_msb,
  input logic         app_msb,
  input logic         rd_peek,
  input logic         rd_clear,
  input logic [W-1:0] set_vec,
  input logic [W-1:0] status,
  input logic [W-1:0] status_rdata,
  input logic         irq_oe
);

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clear |=> ((status & $past(status)) == $past(status)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && set_vec == '0) |=> !irq_oe);

  assert_peek_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_peek && !rd_clear && set_vec == '0) |=> $stable(status));

  assert_keep_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clear |=> status == $past(set_vec));

  assert_read_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_peek || rd_clear) |=> status_rdata == $past(status));

  assert_act_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_msb) |=> status[0]);

  assert_app_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(app_msb) |=> status[W-1]);

  assert_no_irq_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq_oe);

endmodule

bind evt_irq_ctrl evt_irq_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .act_msb      (act_msb),
  .app_msb      (app_msb),
  .rd_peek      (rd_peek),
  .rd_clear     (rd_clear),
  .set_vec      (set_vec),
  .status       (status),
  .status_rdata (status_rdata),
  .irq_oe       (irq_oe)
);

// File: tb/tb_evt_irq_ctrl.sv
module tb_evt_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_in = '0;
  logic        act_msb = 1'b0;
  logic        app_msb = 1'b0;
  logic        mask_wr = 1'b0;
  logic [15:0] mask_wdata = '0;
  logic        rd_peek = 1'b0;
  logic        rd_clear = 1'b0;
  logic [15:0] status;
  logic [15:0] status_rdata;
  logic        irq_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .act_msb(act_msb),
    .app_msb(app_msb), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .rd_peek(rd_peek), .rd_clear(rd_clear), .status(status),
    .status_rdata(status_rdata), .irq_oe(irq_oe)
  );

  // {event pattern, mask, expected irq}
  localparam logic [32:0] VEC [6] = '{
    {16'h0001, 16'h0001, 1'b1},
    {16'h0002, 16'hFFFD, 1'b0},
    {16'h0F00, 16'h0100, 1'b1},
    {16'hA5A5, 16'h5A5A, 1'b0},
    {16'hFFFF, 16'h8000, 1'b1},
    {16'h0000, 16'hFFFF, 1'b0}
  };

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    rd_clear = 1'b1;
    cyc();
    rd_clear = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    // R4: reset state
    chk("R4 status", status, 16'h0000);
    chk("R4 rdata", status_rdata, 16'h0000);
    chk("R4 irq", {15'b0, irq_oe}, 16'h0000);
    rst_n = 1'b1;
    cyc();
    // R9: reset flag after release
    chk("R9 boot flag", status, 16'h0800);
    clear_all();
    chk("R7 rdata", status_rdata, 16'h0800);
    chk("R7 cleared", status, 16'h0000);
    cyc();
    chk("R9 set once", status, 16'h0000);

    // R1 / R3: table of events and masks
    for (int i = 0; i < 6; i++) begin
      clear_all();
      evt_in = VEC[i][32:17];
      mask_wr = 1'b1;
      mask_wdata = VEC[i][16:1];
      cyc();
      evt_in = '0;
      mask_wr = 1'b0;
      chk("R1 flags", status, VEC[i][32:17]);
      chk("R3 irq", {15'b0, irq_oe}, {15'b0, VEC[i][0]});
    end

    // R2: sticky
    clear_all();
    mask_wr = 1'b1;
    mask_wdata = 16'h0020;
    evt_in = 16'h0020;
    cyc();
    evt_in = '0;
    mask_wr = 1'b0;
    repeat (3) cyc();
    chk("R2 sticky", status, 16'h0020);
    // R6: peek read
    rd_peek = 1'b1;
    cyc();
    rd_peek = 1'b0;
    chk("R6 rdata", status_rdata, 16'h0020);
    chk("R6 unchanged", status, 16'h0020);
    chk("R6 irq kept", {15'b0, irq_oe}, 16'h0001);
    // R8: event concurrent with clearing read
    rd_clear = 1'b1;
    evt_in = 16'h0008;
    cyc();
    rd_clear = 1'b0;
    evt_in = '0;
    chk("R8 kept", status, 16'h0008);
    chk("R7 rdata", status_rdata, 16'h0020);
    chk("R7 irq released", {15'b0, irq_oe}, 16'h0000);

    // R10: mask changes irq only
    mask_wr = 1'b1;
    mask_wdata = 16'h0008;
    cyc();
    mask_wr = 1'b0;
    chk("R10 irq", {15'b0, irq_oe}, 16'h0001);
    chk("R10 flags", status, 16'h0008);

    // R5: accumulator rising edges
    clear_all();
    act_msb = 1'b1;
    cyc();
    chk("R5 act", status, 16'h0001);
    cyc();
    clear_all();
    cyc();
    chk("R5 act level", status, 16'h0000);
    app_msb = 1'b1;
    cyc();
    chk("R5 app", status, 16'h8000);
    clear_all();
    cyc();
    chk("R5 app level", status, 16'h0000);
    act_msb = 1'b0;
    app_msb = 1'b0;
    cyc();
    act_msb = 1'b1;
    cyc();
    chk("R5 act again", status, 16'h0001);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule